// File: doc/BRIEF.md
# Stack Pointer Push/Pop Engine

This block owns the 16-bit stack pointer of a small 8/16-bit processor core. It accepts one command at a time and carries it out. A command can move a register pair or the status byte onto the stack or off it. It can also set the pointer, nudge it up or down, or report its value. Each two-byte transfer goes over a byte-wide memory port, one byte per clock. The pointer always moves by two, so the stack keeps an even stride. The status push therefore pads its slot with a zero byte.

The core presents an opcode, a 16-bit pair operand and a 16-bit immediate, together with a valid strobe. The engine raises busy while it works. It pulses done for one clock when the work is finished. In that clock, the updated pointer and any value read back are visible. The memory port uses an asynchronous read: the read data answers the address driven in the same clock.

Top module: `sp_stack_engine`

## Requirements
- R1: While reset is held and after it is released, the pointer output is 0000h, and busy, done, the write strobe and the read strobe are all low.
- R2: Opcode 1 pushes a pair. In the first busy clock, the high operand byte is written to SP-1. In the second busy clock, the low byte is written to SP-2. In the clock after that, done is high and the pointer reads SP-2.
- R3: Opcode 2 pushes the status byte, taken from operand bits 7:0. The status byte is written to SP-1 in the first busy clock and 00h to SP-2 in the second. The pointer then reads SP-2 with done.
- R4: Opcode 3 pops a pair. It reads SP in the first busy clock and SP+1 in the second. With done, the result is {byte at SP+1, byte at SP} and the pointer is SP+2.
- R5: Opcode 4 pops the status byte. It reads only SP+1, in the first of three busy clocks, and no strobe is active in the other two. With done, the result is {00h, that byte} and the pointer is SP+2.
- R6: Opcode 5 loads the pointer from the immediate, and opcode 6 loads it from the pair operand. In both cases, done and the new value appear one clock after acceptance.
- R7: Opcode 7 returns the pointer on the result output with done, one clock after acceptance, and leaves the pointer unchanged.
- R8: Opcode 8 adds immediate bits 7:0, zero-extended, to the pointer, and opcode 9 subtracts them, both modulo 2^16. Immediate bits 15:8 have no effect. Done and the result appear one clock after acceptance.
- R9: Busy is high from the clock after acceptance through the last busy clock of the operation. Done is a single-clock pulse in the clock right after that, and busy is low while done is high.
- R10: A command presented while busy is dropped. Opcodes 0 and 10 to 15 are dropped at any time: they raise no busy, no done and no strobe, and they leave the pointer unchanged.
- R11: The result output changes only on opcodes 3, 4 and 7. On every other opcode, it keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 4 | Opcode (see requirements) |
| cmd_pair | input | 16 | Pair operand; bits 7:0 carry the status byte |
| cmd_imm | input | 16 | Immediate word; bits 7:0 are the adjust amount |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock completion pulse |
| sp_out | output | 16 | Current stack pointer |
| res_data | output | 16 | Popped or copied value |
| mem_addr | output | 16 | Byte address |
| mem_wr | output | 1 | Byte write strobe |
| mem_rd | output | 1 | Byte read strobe |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, answering mem_addr in the same clock |

## Verification
Counting from the clock edge that accepts a command, memory access k of an operation is driven in clock k+1. Done, the new pointer and the result appear N+1 clocks after that edge, where N is 2 for a pair transfer or status push, 3 for a status pop and 1 for the register-only opcodes. The bench keeps a behavioural model of the pointer, the result and the memory bytes. At each falling edge, it compares the strobes, address and data of the current busy clock, then the done clock, and then an idle clock, so every value is read in the exact clock it is due. Commands injected while busy, and dropped opcodes, are checked by confirming that the pointer and strobes stay as the model predicts.

// File: rtl/spe_pkg.sv
package spe_pkg;

   typedef enum logic [3:0] {
      OP_NONE      = 4'd0,
      OP_PUSH_PAIR = 4'd1,
      OP_PUSH_STAT = 4'd2,
      OP_POP_PAIR  = 4'd3,
      OP_POP_STAT  = 4'd4,
      OP_LOAD_IMM  = 4'd5,
      OP_LOAD_PAIR = 4'd6,
      OP_COPY_SP   = 4'd7,
      OP_ADD_IMM   = 4'd8,
      OP_SUB_IMM   = 4'd9
   } spe_op_e;

   // Opcodes the engine acts on; every other code is dropped.
   function automatic logic op_known(logic [3:0] code);
      return (code >= 4'd1) && (code <= 4'd9);
   endfunction

   // Number of busy clocks an opcode occupies.
   function automatic int op_steps(spe_op_e op, int stat_pop_cycles);
      case (op)
         OP_PUSH_PAIR, OP_PUSH_STAT, OP_POP_PAIR: return 2;
         OP_POP_STAT:                             return stat_pop_cycles;
         default:                                 return 1;
      endcase
   endfunction

endpackage

// File: rtl/spe_seq.sv
module spe_seq
   import spe_pkg::*;
#(
   parameter int ADDR_W          = 16,
   parameter int PAIR_W          = 16,
   parameter int POP_STAT_CYCLES = 3,
   parameter int STEP_W          = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [3:0]        cmd_op,
   input  logic [PAIR_W-1:0] cmd_pair,
   input  logic [ADDR_W-1:0] cmd_imm,
   output logic              busy,
   output logic              done,
   output logic              fin,
   output spe_op_e           op_q,
   output logic [STEP_W-1:0] step_q,
   output logic [PAIR_W-1:0] pair_q,
   output logic [ADDR_W-1:0] imm_q
);

   logic [STEP_W-1:0] last_step;
   logic              accept;

   always_comb begin
      last_step = STEP_W'(op_steps(op_q, POP_STAT_CYCLES) - 1);
      fin       = busy && (step_q == last_step);
      accept    = cmd_valid && !busy && op_known(cmd_op);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         done   <= 1'b0;
         op_q   <= OP_NONE;
         step_q <= '0;
         pair_q <= '0;
         imm_q  <= '0;
      end else begin
         done <= fin;
         if (accept) begin
            busy   <= 1'b1;
            step_q <= '0;
            op_q   <= spe_op_e'(cmd_op);
            pair_q <= cmd_pair;
            imm_q  <= cmd_imm;
         end else if (fin) begin
            busy <= 1'b0;
         end else if (busy) begin
            step_q <= step_q + 1'b1;
         end
      end
   end

   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r9_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      fin |=> (done && !busy));
   a_r10_op_locked: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(op_q) && $stable(pair_q));

endmodule

// File: rtl/spe_port.sv
module spe_port
   import spe_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int BYTE_W = 8,
   parameter int STEP_W = 2,
   parameter logic [BYTE_W-1:0] FILL_BYTE = '0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                busy,
   input  spe_op_e             op_q,
   input  logic [STEP_W-1:0]   step_q,
   input  logic [ADDR_W-1:0]   sp_q,
   input  logic [2*BYTE_W-1:0] pair_q,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic                mem_wr,
   output logic                mem_rd,
   output logic [BYTE_W-1:0]   mem_wdata
);

   localparam int PAIR_W = 2 * BYTE_W;

   logic              first;
   logic [ADDR_W-1:0] below1, below2, above1;

   always_comb begin
      first  = (step_q == '0);
      below1 = sp_q - ADDR_W'(1);
      below2 = sp_q - ADDR_W'(2);
      above1 = sp_q + ADDR_W'(1);

      mem_addr  = sp_q;
      mem_wr    = 1'b0;
      mem_rd    = 1'b0;
      mem_wdata = '0;
      if (busy) begin
         case (op_q)
            OP_PUSH_PAIR: begin
               mem_wr    = 1'b1;
               mem_addr  = first ? below1 : below2;
               mem_wdata = first ? pair_q[PAIR_W-1:BYTE_W] : pair_q[BYTE_W-1:0];
            end
            OP_PUSH_STAT: begin
               mem_wr    = 1'b1;
               mem_addr  = first ? below1 : below2;
               mem_wdata = first ? pair_q[BYTE_W-1:0] : FILL_BYTE;
            end
            OP_POP_PAIR: begin
               mem_rd   = 1'b1;
               mem_addr = first ? sp_q : above1;
            end
            OP_POP_STAT: begin
               mem_rd   = first;
               mem_addr = above1;
            end
            default: ;
         endcase
      end
   end

   a_r1_no_rw_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_wr && mem_rd));
   a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_wr && !mem_rd));
   a_r2_write_steps_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && first) |=> (mem_wr && mem_addr == $past(mem_addr) - ADDR_W'(1)));

endmodule

// File: rtl/spe_regs.sv
module spe_regs
   import spe_pkg::*;
#(
   parameter int ADDR_W          = 16,
   parameter int BYTE_W          = 8,
   parameter int ADJ_W           = 8,
   parameter int STEP_W          = 2,
   parameter int POP_STAT_CYCLES = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                busy,
   input  logic                fin,
   input  spe_op_e             op_q,
   input  logic [STEP_W-1:0]   step_q,
   input  logic [2*BYTE_W-1:0] pair_q,
   input  logic [ADDR_W-1:0]   imm_q,
   input  logic [BYTE_W-1:0]   mem_rdata,
   output logic [ADDR_W-1:0]   sp_q,
   output logic [2*BYTE_W-1:0] res_q
);

   localparam int PAIR_W = 2 * BYTE_W;

   logic [ADDR_W-1:0] adj;
   logic [BYTE_W-1:0] lo_q;
   logic [BYTE_W-1:0] stat_byte;
   logic              is_pop;

   generate
      if (ADJ_W < ADDR_W) begin : g_zext
         assign adj = {{(ADDR_W-ADJ_W){1'b0}}, imm_q[ADJ_W-1:0]};
      end else begin : g_full
         assign adj = imm_q[ADDR_W-1:0];
      end
      if (POP_STAT_CYCLES == 1) begin : g_stat_direct
         assign stat_byte = mem_rdata;
      end else begin : g_stat_held
         assign stat_byte = lo_q;
      end
   endgenerate

   assign is_pop = (op_q == OP_POP_PAIR) || (op_q == OP_POP_STAT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sp_q  <= '0;
         res_q <= '0;
         lo_q  <= '0;
      end else begin
         if (busy && is_pop && step_q == '0)
            lo_q <= mem_rdata;
         if (fin) begin
            case (op_q)
               OP_PUSH_PAIR, OP_PUSH_STAT: sp_q <= sp_q - ADDR_W'(2);
               OP_POP_PAIR: begin
                  sp_q  <= sp_q + ADDR_W'(2);
                  res_q <= {mem_rdata, lo_q};
               end
               OP_POP_STAT: begin
                  sp_q  <= sp_q + ADDR_W'(2);
                  res_q <= {{(PAIR_W-BYTE_W){1'b0}}, stat_byte};
               end
               OP_LOAD_IMM:  sp_q  <= imm_q;
               OP_LOAD_PAIR: sp_q  <= pair_q;
               OP_COPY_SP:   res_q <= sp_q;
               OP_ADD_IMM:   sp_q  <= sp_q + adj;
               OP_SUB_IMM:   sp_q  <= sp_q - adj;
               default: ;
            endcase
         end
      end
   end

   a_r2_push_lowers_by_two: assert property (@(posedge clk) disable iff (!rst_n)
      (fin && (op_q == OP_PUSH_PAIR || op_q == OP_PUSH_STAT))
      |=> sp_q == $past(sp_q - ADDR_W'(2)));
   a_r4_pop_raises_by_two: assert property (@(posedge clk) disable iff (!rst_n)
      (fin && is_pop) |=> sp_q == $past(sp_q + ADDR_W'(2)));
   a_r7_copy_keeps_sp: assert property (@(posedge clk) disable iff (!rst_n)
      (fin && op_q == OP_COPY_SP) |=> ($stable(sp_q) && res_q == $past(sp_q)));
   a_r11_res_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (fin && !is_pop && op_q != OP_COPY_SP) |=> $stable(res_q));
   a_r10_sp_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !fin |=> $stable(sp_q));

endmodule

// File: rtl/sp_stack_engine.sv
module sp_stack_engine
   import spe_pkg::*;
#(
   parameter int ADDR_W          = 16,
   parameter int BYTE_W          = 8,
   parameter int ADJ_W           = 8,
   parameter int POP_STAT_CYCLES = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cmd_valid,
   input  logic [3:0]          cmd_op,
   input  logic [2*BYTE_W-1:0] cmd_pair,
   input  logic [ADDR_W-1:0]   cmd_imm,
   output logic                busy,
   output logic                done,
   output logic [ADDR_W-1:0]   sp_out,
   output logic [2*BYTE_W-1:0] res_data,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic                mem_wr,
   output logic                mem_rd,
   output logic [BYTE_W-1:0]   mem_wdata,
   input  logic [BYTE_W-1:0]   mem_rdata
);

   localparam int PAIR_W    = 2 * BYTE_W;
   localparam int MAX_STEPS = (POP_STAT_CYCLES > 2) ? POP_STAT_CYCLES : 2;
   localparam int STEP_W    = (MAX_STEPS > 2) ? $clog2(MAX_STEPS) : 1;

   generate
      if (ADDR_W != PAIR_W) begin : g_bad_width
         $error("sp_stack_engine: ADDR_W must equal twice BYTE_W");
      end
      if (ADJ_W < 1 || ADJ_W > ADDR_W) begin : g_bad_adj
         $error("sp_stack_engine: ADJ_W out of range");
      end
      if (POP_STAT_CYCLES < 1) begin : g_bad_pop
         $error("sp_stack_engine: POP_STAT_CYCLES must be at least 1");
      end
   endgenerate

   logic              fin;
   spe_op_e           op_q;
   logic [STEP_W-1:0] step_q;
   logic [PAIR_W-1:0] pair_q;
   logic [ADDR_W-1:0] imm_q;
   logic [ADDR_W-1:0] sp_q;

   spe_seq #(
      .ADDR_W(ADDR_W), .PAIR_W(PAIR_W),
      .POP_STAT_CYCLES(POP_STAT_CYCLES), .STEP_W(STEP_W)
   ) i_seq (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_pair(cmd_pair), .cmd_imm(cmd_imm),
      .busy(busy), .done(done), .fin(fin),
      .op_q(op_q), .step_q(step_q), .pair_q(pair_q), .imm_q(imm_q)
   );

   spe_port #(
      .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .STEP_W(STEP_W), .FILL_BYTE('0)
   ) i_port (
      .clk(clk), .rst_n(rst_n),
      .busy(busy), .op_q(op_q), .step_q(step_q), .sp_q(sp_q), .pair_q(pair_q),
      .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_wdata(mem_wdata)
   );

   spe_regs #(
      .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .ADJ_W(ADJ_W),
      .STEP_W(STEP_W), .POP_STAT_CYCLES(POP_STAT_CYCLES)
   ) i_regs (
      .clk(clk), .rst_n(rst_n),
      .busy(busy), .fin(fin), .op_q(op_q), .step_q(step_q),
      .pair_q(pair_q), .imm_q(imm_q), .mem_rdata(mem_rdata),
      .sp_q(sp_q), .res_q(res_data)
   );

   assign sp_out = sp_q;

   a_r1_reset_sp_zero: assert property (@(posedge clk)
      !rst_n |=> (sp_out == '0 && !busy && !done));

endmodule

// File: tb/test_sp_stack_engine.sv
`timescale 1ns/1ps
module test_sp_stack_engine;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [3:0]  cmd_op = 4'd0;
   logic [15:0] cmd_pair = '0;
   logic [15:0] cmd_imm = '0;
   logic        busy, done, mem_wr, mem_rd;
   logic [15:0] sp_out, res_data, mem_addr;
   logic [7:0]  mem_wdata, mem_rdata;

   logic [7:0]  ram [0:255];
   logic [7:0]  ref_mem [0:255];
   logic [15:0] ref_sp = '0;
   logic [15:0] ref_res = '0;

   int compared = 0;
   int mismatched = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   sp_stack_engine i_sp_stack_engine (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_pair(cmd_pair), .cmd_imm(cmd_imm),
      .busy(busy), .done(done), .sp_out(sp_out), .res_data(res_data),
      .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_rd(mem_rd),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   assign mem_rdata = ram[mem_addr[7:0]];

   always @(posedge clk)
      if (mem_wr) ram[mem_addr[7:0]] <= mem_wdata;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic check_idle(input string req);
      chk(busy == 1'b0, req, "idle busy", busy, 0);
      chk(done == 1'b0, req, "idle done", done, 0);
      chk(!mem_wr && !mem_rd, req, "idle strobes", {mem_wr, mem_rd}, 0);
      chk(sp_out == ref_sp, req, "idle sp", sp_out, ref_sp);
      chk(res_data == ref_res, req, "idle res", res_data, ref_res);
   endtask

   // Runs one command from a falling edge; checks every busy clock, the done clock and one idle clock.
   task automatic run_op(input logic [3:0] op, input logic [15:0] pair,
                         input logic [15:0] imm, input string req, input bit inject);
      logic        e_wr [0:3];
      logic        e_rd [0:3];
      logic [15:0] e_addr [0:3];
      logic [7:0]  e_wd [0:3];
      logic [15:0] new_sp = ref_sp;
      logic [15:0] new_res = ref_res;
      int n = 1;
      for (int k = 0; k < 4; k++) begin
         e_wr[k] = 0; e_rd[k] = 0; e_addr[k] = 'x; e_wd[k] = 'x;
      end
      case (op)
         4'd1, 4'd2: begin
            n = 2;
            e_wr[0] = 1; e_addr[0] = ref_sp - 16'd1;
            e_wd[0] = (op == 4'd1) ? pair[15:8] : pair[7:0];
            e_wr[1] = 1; e_addr[1] = ref_sp - 16'd2;
            e_wd[1] = (op == 4'd1) ? pair[7:0] : 8'h00;
            new_sp = ref_sp - 16'd2;
         end
         4'd3: begin
            n = 2;
            e_rd[0] = 1; e_addr[0] = ref_sp;
            e_rd[1] = 1; e_addr[1] = ref_sp + 16'd1;
            new_res = {ref_mem[8'(ref_sp + 16'd1)], ref_mem[8'(ref_sp)]};
            new_sp = ref_sp + 16'd2;
         end
         4'd4: begin
            n = 3;
            e_rd[0] = 1; e_addr[0] = ref_sp + 16'd1;
            new_res = {8'h00, ref_mem[8'(ref_sp + 16'd1)]};
            new_sp = ref_sp + 16'd2;
         end
         4'd5: new_sp = imm;
         4'd6: new_sp = pair;
         4'd7: new_res = ref_sp;
         4'd8: new_sp = ref_sp + {8'h00, imm[7:0]};
         4'd9: new_sp = ref_sp - {8'h00, imm[7:0]};
         default: ;
      endcase

      cmd_valid = 1'b1; cmd_op = op; cmd_pair = pair; cmd_imm = imm;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         cmd_valid = 1'b0;
         if (inject && k == 0 && n > 1) begin
            // R10: a load presented while busy must be dropped
            cmd_valid = 1'b1; cmd_op = 4'd5; cmd_imm = 16'h1234;
         end
         chk(busy == 1'b1, "R9", "busy during step", busy, 1);
         chk(done == 1'b0, "R9", "done during step", done, 0);
         chk(mem_wr == e_wr[k], req, "write strobe", mem_wr, e_wr[k]);
         chk(mem_rd == e_rd[k], req, "read strobe", mem_rd, e_rd[k]);
         if (e_wr[k] || e_rd[k])
            chk(mem_addr == e_addr[k], req, "address", mem_addr, e_addr[k]);
         if (e_wr[k]) begin
            chk(mem_wdata == e_wd[k], req, "write byte", mem_wdata, e_wd[k]);
            ref_mem[e_addr[k][7:0]] = e_wd[k];
         end
      end
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(done == 1'b1, "R9", "done pulse", done, 1);
      chk(busy == 1'b0, "R9", "busy with done", busy, 0);
      chk(!mem_wr && !mem_rd, req, "strobes with done", {mem_wr, mem_rd}, 0);
      chk(sp_out == new_sp, req, "new sp", sp_out, new_sp);
      chk(res_data == new_res, req, "result", res_data, new_res);
      ref_sp = new_sp;
      ref_res = new_res;
      @(negedge clk);
      check_idle(inject ? "R10" : "R9");
   endtask

   task automatic drop_op(input logic [3:0] op);
      cmd_valid = 1'b1; cmd_op = op; cmd_pair = 16'hFFFF; cmd_imm = 16'hFFFF;
      @(negedge clk);
      cmd_valid = 1'b0;
      check_idle("R10");
      @(negedge clk);
      check_idle("R10");
   endtask

   initial begin
      #(8 * 100000);
      if (!finished) begin
         mismatched++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 256; i++) begin
         ram[i] = 8'h00; ref_mem[i] = 8'h00;
      end
      repeat (3) @(negedge clk);
      check_idle("R1");            // R1 while reset held
      rst_n = 1'b1;
      @(negedge clk);
      check_idle("R1");            // R1 after release

      run_op(4'd1, 16'hA55A, 16'h0000, "R2", 0);   // wraps below 0000h
      run_op(4'd2, 16'h7783, 16'h0000, "R3", 1);   // R10 injection while busy
      run_op(4'd7, 16'h0000, 16'h0000, "R7", 0);
      run_op(4'd4, 16'h0000, 16'h0000, "R5", 0);
      run_op(4'd3, 16'h0000, 16'h0000, "R4", 0);
      run_op(4'd5, 16'h0000, 16'h0040, "R6", 0);   // R11 result holds
      run_op(4'd1, 16'h1234, 16'h0000, "R2", 0);
      run_op(4'd1, 16'hBEEF, 16'h0000, "R2", 1);
      run_op(4'd3, 16'h0000, 16'h0000, "R4", 1);
      run_op(4'd3, 16'h0000, 16'h0000, "R4", 0);
      run_op(4'd6, 16'h00F0, 16'h0000, "R6", 0);
      run_op(4'd8, 16'h0000, 16'hAB10, "R8", 0);   // upper immediate ignored
      run_op(4'd9, 16'h0000, 16'h0020, "R8", 0);
      run_op(4'd5, 16'h0000, 16'hFFF8, "R6", 0);
      run_op(4'd8, 16'h0000, 16'h000C, "R8", 0);   // wraps past FFFFh
      run_op(4'd9, 16'h0000, 16'h0005, "R8", 0);   // wraps below 0000h
      run_op(4'd2, 16'h00C1, 16'h0000, "R3", 0);
      run_op(4'd4, 16'h0000, 16'h0000, "R5", 1);
      run_op(4'd7, 16'h0000, 16'h0000, "R11", 0);
      run_op(4'd9, 16'h0000, 16'h00FF, "R11", 0);
      drop_op(4'd0);
      drop_op(4'd10);
      drop_op(4'd15);

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule